// File: doc/BRIEF.md
# CORDIC IQ Demodulator with Decimation

The block turns a stream of real, signed samples taken from an undersampled RF reference into a low-rate complex baseband stream. Undersampling leaves the carrier folded down to an alias frequency. A phase accumulator, stepped by a programmable increment, tracks that alias. A pipelined shift-and-add CORDIC rotator turns each accumulated phase into a cosine and sine pair.

Each sample is multiplied by both local oscillator outputs. The in-phase and quadrature products are then summed over a programmable window of R samples. This first-order CIC (integrate and dump) acts as both the low-pass filter and the decimator. One I/Q pair leaves for every R accepted samples, so the output rate can be set to a small multiple of the narrow signal bandwidth.

The sample travels through the rotator pipeline next to its own angle. I and Q therefore stay aligned to the input stream whatever the iteration count.

Top module: `cordic_iq_demod`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and i_o and q_o are 0. After reset is released, the first accepted sample is mixed at phase 0.
- R2: The k-th accepted sample after reset (k counting from 0) is mixed at phase k·phase_inc_i modulo 2^PHASE_W, where 2^PHASE_W phase units make one full turn. The phase advances only on cycles with sample_valid_i high.
- R3: The local oscillator is A·cos and A·sin of that phase, with A = 2^(LO_W-1)-1. It comes from ITER pipelined CORDIC iterations that start from a vector pre-scaled by about 0.6073. The two most significant phase bits select the quadrant. The rotator accepts one angle per clock.
- R4: The cosine and sine values are rounded from guard bits and saturated to the range [-A, A].
- R5: For each sample x (signed, two's complement), the in-phase product is x·cos and the quadrature product is -(x·sin). The sample is carried through the rotator pipeline together with its own angle.
- R6: One output pair is produced for every R accepted samples, with R = dec_ratio_i. The values 0 and 1 both mean that every sample produces an output. Each output is the sum of the products of the R samples in its window, and the windows do not overlap.
- R7: out_valid_o is high for one cycle per output pair. i_o and q_o hold their value until the next output pair.
- R8: Each output is floor(sum / 2^OUT_SHIFT), saturated to the signed OUT_W range [-2^(OUT_W-1), 2^(OUT_W-1)-1].
- R9: Cycles with sample_valid_i low do not change the phase, the window count or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Qualifies sample_i |
| sample_i | input | DATA_W | Signed input sample |
| phase_inc_i | input | PHASE_W | Phase step per accepted sample (2^PHASE_W units per turn) |
| dec_ratio_i | input | DEC_W | Decimation ratio R (0 is treated as 1) |
| out_valid_o | output | 1 | One-cycle strobe for each output pair |
| i_o | output | OUT_W | In-phase output, signed |
| q_o | output | OUT_W | Quadrature output, signed |

## Verification
The assertions assume three things about the inputs:
- phase_inc_i and dec_ratio_i are set while reset is held and stay constant until the next reset;
- sample_i can take any value, including the most negative code;
- the local oscillator magnitude never exceeds A, so negating the quadrature product cannot overflow.

The stimulus reconfigures only under reset. It drives every sample pattern from tables that include -128 and +127. Gaps in sample_valid_i are inserted on a fixed cycle pattern. The expected values come from a floating-point model of mixing and summing, with a tolerance that grows with R to cover the rounding in the rotator.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

  // 1/K for the CORDIC gain, Q16 (0.60725 * 65536)
  localparam int unsigned KGAIN_Q16 = 39797;

  // atan(2^-i) in units of 2^32 per full turn
  function automatic logic [31:0] atan_turn32(input int unsigned idx);
    case (idx)
      0:       return 32'h2000_0000;
      1:       return 32'h12E4_051D;
      2:       return 32'h09FB_385B;
      3:       return 32'h0511_11D4;
      4:       return 32'h028B_0D43;
      5:       return 32'h0145_D7E1;
      6:       return 32'h00A2_F61E;
      7:       return 32'h0051_7C55;
      8:       return 32'h0028_BE53;
      9:       return 32'h0014_5F2E;
      default: return 32'd683565276 >> idx;  // small-angle: 2^32/(2*pi) * 2^-i
    endcase
  endfunction

endpackage

// File: rtl/iqd_phase_acc.sv
module iqd_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_i) phase_q <= phase_q + inc_i;  // wraps modulo one turn
  end

  assign phase_o = phase_q;

  // R2, R9: no sample, no phase movement
  a_r2_hold_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));

endmodule

// File: rtl/iqd_cordic.sv
module iqd_cordic #(
  parameter int TAG_W   = 8,
  parameter int PHASE_W = 16,
  parameter int LO_W    = 12,
  parameter int GUARD   = 3,
  parameter int ITER    = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [PHASE_W-1:0]     phase_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic                   valid_o,
  output logic signed [LO_W-1:0] cos_o,
  output logic signed [LO_W-1:0] sin_o,
  output logic [TAG_W-1:0]       tag_o
);

  localparam int CW         = LO_W + GUARD + 2;
  localparam int ZW         = PHASE_W + 2;
  localparam int LO_AMP     = (1 << (LO_W - 1)) - 1;
  localparam int X_INIT     = int'((longint'(LO_AMP << GUARD) * longint'(iqd_pkg::KGAIN_Q16)) >>> 16);
  localparam int ROUND_HALF = 1 << (GUARD - 1);
  localparam int LAT        = ITER + 2;
  localparam int FW         = $clog2(LAT + 1) + 1;

  logic signed [CW-1:0] x_q    [ITER+1];
  logic signed [CW-1:0] y_q    [ITER+1];
  logic signed [ZW-1:0] z_q    [ITER+1];
  logic [1:0]           quad_q [ITER+1];
  logic [TAG_W-1:0]     tag_q  [ITER+1];
  logic                 vld_q  [ITER+1];

  // Stage 0: fold into first quadrant, load the pre-scaled vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[0]  <= 1'b0;
      x_q[0]    <= '0;
      y_q[0]    <= '0;
      z_q[0]    <= '0;
      quad_q[0] <= '0;
      tag_q[0]  <= '0;
    end else begin
      vld_q[0]  <= valid_i;
      x_q[0]    <= CW'(X_INIT);
      y_q[0]    <= '0;
      z_q[0]    <= $signed({2'b00, phase_i[PHASE_W-3:0], 2'b00});
      quad_q[0] <= phase_i[PHASE_W-1 -: 2];
      tag_q[0]  <= tag_i;
    end
  end

  for (genvar k = 0; k < ITER; k++) begin : g_iter
    localparam logic [31:0]          ATAN_RAW = iqd_pkg::atan_turn32(k);
    localparam logic signed [ZW-1:0] ATAN_K   = $signed(ZW'(ATAN_RAW >> (32 - ZW)));

    logic signed [CW-1:0] x_sh, y_sh;
    assign x_sh = x_q[k] >>> k;
    assign y_sh = y_q[k] >>> k;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k+1]  <= 1'b0;
        x_q[k+1]    <= '0;
        y_q[k+1]    <= '0;
        z_q[k+1]    <= '0;
        quad_q[k+1] <= '0;
        tag_q[k+1]  <= '0;
      end else begin
        vld_q[k+1]  <= vld_q[k];
        quad_q[k+1] <= quad_q[k];
        tag_q[k+1]  <= tag_q[k];
        if (z_q[k][ZW-1]) begin
          x_q[k+1] <= x_q[k] + y_sh;
          y_q[k+1] <= y_q[k] - x_sh;
          z_q[k+1] <= z_q[k] + ATAN_K;
        end else begin
          x_q[k+1] <= x_q[k] - y_sh;
          y_q[k+1] <= y_q[k] + x_sh;
          z_q[k+1] <= z_q[k] - ATAN_K;
        end
      end
    end
  end

  function automatic logic signed [LO_W-1:0] lo_round(input logic signed [CW-1:0] v);
    logic signed [CW:0] r;
    r = $signed({v[CW-1], v}) + $signed((CW+1)'(ROUND_HALF));
    r = r >>> GUARD;
    if (r > LO_AMP)  return LO_W'(LO_AMP);
    if (r < -LO_AMP) return LO_W'(-LO_AMP);
    return r[LO_W-1:0];
  endfunction

  logic signed [LO_W-1:0] c_rnd, s_rnd, cos_d, sin_d;

  always_comb begin
    c_rnd = lo_round(x_q[ITER]);
    s_rnd = lo_round(y_q[ITER]);
    unique case (quad_q[ITER])
      2'd0:    begin cos_d =  c_rnd; sin_d =  s_rnd; end
      2'd1:    begin cos_d = -s_rnd; sin_d =  c_rnd; end
      2'd2:    begin cos_d = -c_rnd; sin_d = -s_rnd; end
      default: begin cos_d =  s_rnd; sin_d = -c_rnd; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cos_o   <= '0;
      sin_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= vld_q[ITER];
      cos_o   <= cos_d;
      sin_o   <= sin_d;
      tag_o   <= tag_q[ITER];
    end
  end

  // R4: oscillator bounded by the amplitude
  a_r4_lo_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cos_o <= LO_AMP && cos_o >= -LO_AMP && sin_o <= LO_AMP && sin_o >= -LO_AMP));

  // R5: no more samples in flight than pipeline stages
  logic [FW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else begin
      case ({valid_i, valid_o})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  a_r5_pipe_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= FW'(LAT));

endmodule

// File: rtl/iqd_mixer.sv
module iqd_mixer #(
  parameter int DATA_W = 8,
  parameter int LO_W   = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic [DATA_W-1:0]              sample_i,
  input  logic signed [LO_W-1:0]         cos_i,
  input  logic signed [LO_W-1:0]         sin_i,
  output logic                           valid_o,
  output logic signed [DATA_W+LO_W-1:0]  i_prod_o,
  output logic signed [DATA_W+LO_W-1:0]  q_prod_o
);

  localparam int PROD_W = DATA_W + LO_W;

  logic signed [PROD_W-1:0] p_cos, p_sin;

  // |sample * lo| < 2^(PROD_W-1), so the negation cannot overflow
  assign p_cos = $signed(sample_i) * cos_i;
  assign p_sin = $signed(sample_i) * sin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      i_prod_o <= '0;
      q_prod_o <= '0;
    end else begin
      valid_o  <= valid_i;
      i_prod_o <= p_cos;
      q_prod_o <= -p_sin;
    end
  end

endmodule

// File: rtl/iqd_cic.sv
module iqd_cic #(
  parameter int PROD_W    = 20,
  parameter int DEC_W     = 8,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [PROD_W-1:0] i_prod_i,
  input  logic signed [PROD_W-1:0] q_prod_i,
  input  logic [DEC_W-1:0]         ratio_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  i_o,
  output logic signed [OUT_W-1:0]  q_o
);

  localparam int ACC_W = PROD_W + DEC_W;

  logic [DEC_W-1:0]        cnt_q, ratio_eff;
  logic signed [ACC_W-1:0] acc_i_q, acc_q_q;
  logic signed [ACC_W-1:0] ext_i, ext_q, sum_i, sum_q, sh_i, sh_q;
  logic                    last;

  function automatic logic signed [OUT_W-1:0] sat_out(input logic signed [ACC_W-1:0] v);
    if (&v[ACC_W-1:OUT_W-1] || ~|v[ACC_W-1:OUT_W-1]) return v[OUT_W-1:0];
    if (v[ACC_W-1]) return {1'b1, {(OUT_W-1){1'b0}}};
    return {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  always_comb begin
    ratio_eff = (ratio_i == '0) ? DEC_W'(1) : ratio_i;
    ext_i     = {{(ACC_W-PROD_W){i_prod_i[PROD_W-1]}}, i_prod_i};
    ext_q     = {{(ACC_W-PROD_W){q_prod_i[PROD_W-1]}}, q_prod_i};
    sum_i     = (cnt_q == '0) ? ext_i : acc_i_q + ext_i;
    sum_q     = (cnt_q == '0) ? ext_q : acc_q_q + ext_q;
    sh_i      = sum_i >>> OUT_SHIFT;
    sh_q      = sum_q >>> OUT_SHIFT;
    last      = ({1'b0, cnt_q} + 1'b1) >= {1'b0, ratio_eff};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      acc_i_q     <= '0;
      acc_q_q     <= '0;
      out_valid_o <= 1'b0;
      i_o         <= '0;
      q_o         <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (in_valid_i) begin
        if (last) begin
          cnt_q       <= '0;
          out_valid_o <= 1'b1;
          i_o         <= sat_out(sh_i);
          q_o         <= sat_out(sh_q);
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          acc_i_q <= sum_i;
          acc_q_q <= sum_q;
        end
      end
    end
  end

  // R7: an output only follows an accepted product
  a_r7_out_follows_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  // R6: a new window starts right after each emitted pair
  a_r6_restart_after_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> cnt_q == '0);

endmodule

// File: rtl/cordic_iq_demod.sv
module cordic_iq_demod #(
  parameter int DATA_W    = 8,
  parameter int PHASE_W   = 16,
  parameter int LO_W      = 12,
  parameter int GUARD     = 3,
  parameter int ITER      = 12,
  parameter int DEC_W     = 8,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [PHASE_W-1:0] phase_inc_i,
  input  logic [DEC_W-1:0]   dec_ratio_i,
  output logic               out_valid_o,
  output logic [OUT_W-1:0]   i_o,
  output logic [OUT_W-1:0]   q_o
);

  localparam int PROD_W = DATA_W + LO_W;

  logic [PHASE_W-1:0]       phase;
  logic                     lo_valid, mix_valid;
  logic signed [LO_W-1:0]   lo_cos, lo_sin;
  logic [DATA_W-1:0]        lo_tag;
  logic signed [PROD_W-1:0] i_prod, q_prod;
  logic signed [OUT_W-1:0]  i_s, q_s;

  iqd_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (sample_valid_i),
    .inc_i   (phase_inc_i),
    .phase_o (phase)
  );

  iqd_cordic #(
    .TAG_W(DATA_W), .PHASE_W(PHASE_W), .LO_W(LO_W), .GUARD(GUARD), .ITER(ITER)
  ) u_cordic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .phase_i (phase),
    .tag_i   (sample_i),
    .valid_o (lo_valid),
    .cos_o   (lo_cos),
    .sin_o   (lo_sin),
    .tag_o   (lo_tag)
  );

  iqd_mixer #(.DATA_W(DATA_W), .LO_W(LO_W)) u_mixer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (lo_valid),
    .sample_i (lo_tag),
    .cos_i    (lo_cos),
    .sin_i    (lo_sin),
    .valid_o  (mix_valid),
    .i_prod_o (i_prod),
    .q_prod_o (q_prod)
  );

  iqd_cic #(
    .PROD_W(PROD_W), .DEC_W(DEC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)
  ) u_cic (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (mix_valid),
    .i_prod_i    (i_prod),
    .q_prod_i    (q_prod),
    .ratio_i     (dec_ratio_i),
    .out_valid_o (out_valid_o),
    .i_o         (i_s),
    .q_o         (q_s)
  );

  assign i_o = i_s;
  assign q_o = q_s;

endmodule

// File: tb/cordic_iq_demod_tb_top.sv
module cordic_iq_demod_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  DATA_W     = 8;
  localparam int  PHASE_W    = 16;
  localparam int  LO_W       = 12;
  localparam int  DEC_W      = 8;
  localparam int  OUT_W      = 16;
  localparam int  OUT_SHIFT  = 8;
  localparam real PI         = 3.14159265358979;
  localparam real AMP        = real'((1 << (LO_W - 1)) - 1);
  localparam real TURN       = real'(1 << PHASE_W);
  localparam real OMAX       = real'((1 << (OUT_W - 1)) - 1);
  localparam real OMIN       = -real'(1 << (OUT_W - 1));

  logic                      clk = 1'b0;
  logic                      rst_ni = 1'b0;
  logic                      sample_valid_i = 1'b0;
  logic [DATA_W-1:0]         sample_i = '0;
  logic [PHASE_W-1:0]        phase_inc_i = '0;
  logic [DEC_W-1:0]          dec_ratio_i = '0;
  logic                      out_valid_o;
  logic signed [OUT_W-1:0]   i_o, q_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cordic_iq_demod dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_i       (sample_i),
    .phase_inc_i    (phase_inc_i),
    .dec_ratio_i    (dec_ratio_i),
    .out_valid_o    (out_valid_o),
    .i_o            (i_o),
    .q_o            (q_o)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;
  int  got_i[$], got_q[$];
  real exp_i[$], exp_q[$];
  int  last_i, last_q;
  bit  hold_bad;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst_ni) begin
      last_i = 0;
      last_q = 0;
    end else if (out_valid_o) begin
      got_i.push_back(int'(i_o));
      got_q.push_back(int'(q_o));
      last_i = int'(i_o);
      last_q = int'(q_o);
    end else if (int'(i_o) != last_i || int'(q_o) != last_q) begin
      hold_bad = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input real act, input real expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0.1f expected %0.1f", req, what, act, expv);
    end
  endtask

  function automatic int sample_at(input int pat, input int cval, input int n);
    case (pat)
      0:       return cval;
      1:       return ((n * 37 + 11) % 256) - 128;
      default: return (n % 2 == 0) ? 127 : -128;
    endcase
  endfunction

  function automatic real sat_real(input real v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic run_case(input string tag, input int inc, input int ratio, input int pat,
                          input int cval, input int n, input bit gaps);
    int  reff = (ratio == 0) ? 1 : ratio;
    real tol  = 3.0 * real'(reff) + 3.0;
    real acc_i = 0.0, acc_q = 0.0;
    int  cnt = 0, sent = 0, cyc = 0;
    @(negedge clk);
    rst_ni         = 1'b0;
    sample_valid_i = 1'b0;
    phase_inc_i    = inc[PHASE_W-1:0];
    dec_ratio_i    = ratio[DEC_W-1:0];
    repeat (2) @(negedge clk);
    got_i.delete(); got_q.delete(); exp_i.delete(); exp_q.delete();
    hold_bad = 1'b0;
    rst_ni   = 1'b1;
    while (sent < n) begin
      @(negedge clk);
      cyc++;
      if (gaps && (cyc % 3 == 1)) begin
        sample_valid_i = 1'b0;
        sample_i       = 8'h5A;  // ignored (R9)
      end else begin
        int  x   = sample_at(pat, cval, sent);
        real ang = 2.0 * PI * real'((longint'(sent) * longint'(inc)) % (longint'(1) << PHASE_W)) / TURN;
        sample_valid_i = 1'b1;
        sample_i       = x[DATA_W-1:0];
        acc_i += real'(x) * AMP * $cos(ang);
        acc_q -= real'(x) * AMP * $sin(ang);
        cnt++;
        sent++;
        if (cnt == reff) begin
          exp_i.push_back(sat_real($floor(acc_i / real'(1 << OUT_SHIFT))));
          exp_q.push_back(sat_real($floor(acc_q / real'(1 << OUT_SHIFT))));
          acc_i = 0.0;
          acc_q = 0.0;
          cnt   = 0;
        end
      end
    end
    @(negedge clk);
    sample_valid_i = 1'b0;
    repeat (40) @(negedge clk);
    check(got_i.size() == exp_i.size(), "R6", {tag, " output count"},
          real'(got_i.size()), real'(exp_i.size()));
    for (int k = 0; k < exp_i.size() && k < got_i.size(); k++) begin
      check(absr(real'(got_i[k]) - exp_i[k]) <= tol, "R5", {tag, " I"}, real'(got_i[k]), exp_i[k]);
      check(absr(real'(got_q[k]) - exp_q[k]) <= tol, "R5", {tag, " Q"}, real'(got_q[k]), exp_q[k]);
    end
    check(!hold_bad, "R7", {tag, " hold between strobes"}, real'(hold_bad), 0.0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R1", "reset valid", real'(out_valid_o), 0.0);
    check(i_o == '0 && q_o == '0, "R1", "reset data", real'(i_o), 0.0);

    run_case("R1 phase zero start", 0, 1, 0, 100, 8, 0);
    run_case("R2 quarter step", 16384, 4, 1, 0, 40, 0);
    run_case("R2 half step", 32768, 16, 2, 0, 64, 0);
    run_case("R3 odd step", 12345, 8, 1, 0, 96, 0);
    run_case("R6 ratio zero", 3000, 0, 1, 0, 20, 0);
    run_case("R9 gapped input", 1000, 5, 1, 0, 50, 1);
    run_case("R2 wrap step", 65535, 2, 1, 0, 30, 0);
    run_case("R8 positive saturation", 0, 255, 0, 127, 510, 0);
    run_case("R8 negative saturation", 0, 255, 0, -128, 255, 0);
    run_case("R4 full scale edge", 8192, 1, 2, 0, 16, 0);

    for (int k = 0; k < 16; k++)
      run_case("R3 quadrant sweep", k * 4096 + 7 * k, 1 + (k % 4) * 3, 1, 0, 24, 0);

    // reset in the middle of traffic
    @(negedge clk);
    phase_inc_i = 16'd777;
    dec_ratio_i = 8'd1;
    for (int k = 0; k < 30; k++) begin
      sample_valid_i = 1'b1;
      sample_i       = 8'(k * 9);
      @(negedge clk);
    end
    rst_ni = 1'b0;
    #1;
    check(out_valid_o == 1'b0, "R1", "mid-stream reset valid", real'(out_valid_o), 0.0);
    check(i_o == '0 && q_o == '0, "R1", "mid-stream reset data", real'(i_o), 0.0);
    sample_valid_i = 1'b0;
    run_case("R1 restart phase", 5000, 1, 0, 90, 6, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule